// File: doc/BRIEF.md
# Floating-point significand rounding unit

This block is the last stage of a single-precision floating-point datapath. It comes after alignment, addition and normalisation. It receives a sign, a biased 8-bit exponent and a 24-bit significand whose hidden bit sits at bit 23. It also receives the three bits that lie below the last kept place: guard (worth half a unit in the last place), round, and sticky (the OR of everything shifted out below round). It applies one of four rounding rules and returns the packed 32-bit word.

Rounding can carry out of the significand. When that happens the block shifts the significand right by one place and adds one to the exponent. A subnormal that rounds up into the hidden-bit position becomes the smallest normal number. An exponent that reaches the all-ones value saturates to infinity or to the largest finite magnitude, depending on the rule. Two flags come with the packed word: overflow, and inexact (some discarded bit was set). All three outputs are registered, one cycle after the inputs.

Top module: `fp_round_stage`

## Requirements
- R1: While `rst_n` is low, `result_o`, `overflow_o` and `inexact_o` are all zero.
- R2: Outputs appear on the clock edge after the inputs are presented. `result_o[31]` always equals the input sign. An exact input (guard, round and sticky all 0) with an exponent from 1 to 254 is passed through as {sign, exponent, sig_i[22:0]}.
- R3: With mode 2'b00 (nearest, ties to even), the significand is kept when guard is 0. It is incremented when guard is 1 and round or sticky is 1.
- R4: With mode 2'b00 and an exact half (guard 1, round 0, sticky 0), the significand is incremented only when sig_i[0] is 1, so the kept LSB ends up 0.
- R5: With mode 2'b01 (toward zero), the significand is never incremented.
- R6: With mode 2'b10 (toward +infinity) the magnitude is incremented only for a positive sign. With mode 2'b11 (toward −infinity) it is incremented only for a negative sign. In both modes the increment also needs at least one of guard, round, sticky to be 1.
- R7: When incrementing carries out of bit 23, the exponent field rises by one and the fraction field becomes 0.
- R8: With exponent 0 (subnormal, sig_i[23] = 0), a round-up that sets bit 23 gives exponent field 1 and fraction field 0.
- R9: When the resulting exponent reaches 255, `overflow_o` is 1. The magnitude is infinity (0x7F800000) for mode 00, for mode 10 with a positive sign, and for mode 11 with a negative sign. In every other case it is the largest finite value (0x7F7FFFFF). The sign is kept.
- R10: `inexact_o` equals guard OR round OR sticky of the inputs from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sign_i | input | 1 | Sign of the value |
| exp_i | input | 8 | Biased exponent, 0 for subnormal |
| sig_i | input | 24 | Significand, hidden bit at bit 23 |
| guard_i | input | 1 | First discarded bit (half ulp) |
| round_i | input | 1 | Second discarded bit |
| sticky_i | input | 1 | OR of all lower discarded bits |
| mode_i | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward −inf |
| result_o | output | 32 | Packed sign, exponent, fraction |
| overflow_o | output | 1 | Exponent saturated |
| inexact_o | output | 1 | Some discarded bit was 1 |

## Verification
Every result and both flags are due exactly one rising edge after the input set that produced them. The bench drives a new set on each falling edge. On the next falling edge it compares all three outputs against the reference value it queued for that set. Sampling falls half a period away from the capturing edge, so each comparison sees only the registered response to one input set. The reset value is checked on a falling edge while reset is still held.

// File: rtl/fp_round_stage.sv
module fp_round_stage #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sign_i,
  input  logic [EXP_W-1:0]          exp_i,
  input  logic [FRAC_W:0]           sig_i,
  input  logic                      guard_i,
  input  logic                      round_i,
  input  logic                      sticky_i,
  input  logic [1:0]                mode_i,
  output logic [EXP_W+FRAC_W:0]     result_o,
  output logic                      overflow_o,
  output logic                      inexact_o
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] EXP_TOP = {EXP_W{1'b1}};
  localparam logic [W-2:0] MAG_INF = {EXP_TOP, {FRAC_W{1'b0}}};
  localparam logic [W-2:0] MAG_MAX = {EXP_TOP - 1'b1, {FRAC_W{1'b1}}};

  wire lost = guard_i | round_i | sticky_i;

  logic bump;
  always_comb begin
    case (mode_i)
      2'b00:   bump = guard_i & (round_i | sticky_i | sig_i[0]);
      2'b01:   bump = 1'b0;
      2'b10:   bump = lost & ~sign_i;
      default: bump = lost & sign_i;
    endcase
  end

  wire [SIG_W:0]    sum   = {1'b0, sig_i} + {{SIG_W{1'b0}}, bump};
  wire              carry = sum[SIG_W];
  wire [FRAC_W-1:0] frac  = carry ? sum[FRAC_W:1] : sum[FRAC_W-1:0];
  wire              promo = (exp_i == '0) & sum[FRAC_W];
  wire [EXP_W:0]    exp_n = {1'b0, exp_i} + {{EXP_W{1'b0}}, carry | promo};
  wire              ovf_n = exp_n >= {1'b0, EXP_TOP};
  wire              to_inf = (mode_i == 2'b00) | (mode_i == 2'b10 & ~sign_i) |
                             (mode_i == 2'b11 & sign_i);

  wire [W-2:0] mag_n = ovf_n ? (to_inf ? MAG_INF : MAG_MAX) : {exp_n[EXP_W-1:0], frac};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o   <= '0;
      overflow_o <= 1'b0;
      inexact_o  <= 1'b0;
    end else begin
      result_o   <= {sign_i, mag_n};
      overflow_o <= ovf_n;
      inexact_o  <= lost;
    end
  end

  always @(negedge clk)
    if (!rst_n) AST_RESET_ZERO: assert (result_o == '0 && !overflow_o && !inexact_o); // R1

  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> result_o[W-1] == $past(sign_i)); // R2

  AST_EXACT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(guard_i | round_i | sticky_i) && exp_i != '0 && exp_i != EXP_TOP)
    |=> result_o == {$past(sign_i), $past(exp_i), $past(sig_i[FRAC_W-1:0])}); // R2

  AST_TRUNC_NO_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && exp_i != '0 && exp_i != EXP_TOP)
    |=> result_o[FRAC_W-1:0] == $past(sig_i[FRAC_W-1:0]) && !overflow_o); // R5

  AST_INEXACT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> inexact_o == ($past(guard_i) | $past(round_i) | $past(sticky_i))); // R10

  AST_OVF_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (result_o[W-2:0] == MAG_INF || result_o[W-2:0] == MAG_MAX)); // R9
endmodule

// File: tb/fp_round_stage_bench.sv
`timescale 1ns/1ps
module fp_round_stage_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sign_i = 1'b0;
  logic [7:0]  exp_i = '0;
  logic [23:0] sig_i = '0;
  logic        guard_i = 1'b0, round_i = 1'b0, sticky_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [31:0] result_o;
  logic        overflow_o, inexact_o;

  int compared = 0;
  int mismatched = 0;
  logic [33:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  fp_round_stage u_fp_round_stage (
    .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i),
    .guard_i(guard_i), .round_i(round_i), .sticky_i(sticky_i), .mode_i(mode_i),
    .result_o(result_o), .overflow_o(overflow_o), .inexact_o(inexact_o)
  );

  function automatic logic [33:0] model(input logic s, input logic [7:0] e,
      input logic [23:0] m, input logic g, input logic r, input logic st,
      input logic [1:0] md);
    int q = g * 4 + r * 2 + st;
    bit up;
    int mag;
    int ex;
    logic [30:0] body;
    bit ov;
    case (md)
      2'd0: up = (q > 4) || (q == 4 && m[0]);
      2'd1: up = 0;
      2'd2: up = (q != 0) && !s;
      default: up = (q != 0) && s;
    endcase
    mag = int'(m) + int'(up);
    ex = int'(e);
    if (mag == (1 << 24)) begin mag = mag / 2; ex = ex + 1; end
    if (ex == 0 && mag >= (1 << 23)) ex = 1;
    ov = ex >= 255;
    if (ov)
      body = ((md == 2'd0) || (md == 2'd2 && !s) || (md == 2'd3 && s)) ? 31'h7F800000 : 31'h7F7FFFFF;
    else
      body = {ex[7:0], mag[22:0]};
    return {ov, (q != 0), s, body};
  endfunction

  task automatic compare_one();
    logic [33:0] want;
    string tag;
    if (exp_q.size() == 0) return;
    want = exp_q.pop_front();
    tag = tag_q.pop_front();
    compared++;
    if ({overflow_o, inexact_o, result_o} !== want) begin
      mismatched++;
      $display("FAIL %s: got ovf=%b inx=%b res=%h, expected ovf=%b inx=%b res=%h",
               tag, overflow_o, inexact_o, result_o, want[33], want[32], want[31:0]);
    end
  endtask

  task automatic step(input string tag, input logic s, input logic [7:0] e,
      input logic [23:0] m, input logic g, input logic r, input logic st,
      input logic [1:0] md);
    @(negedge clk);
    compare_one();
    sign_i = s; exp_i = e; sig_i = m; guard_i = g; round_i = r; sticky_i = st; mode_i = md;
    exp_q.push_back(model(s, e, m, g, r, st, md));
    tag_q.push_back(tag);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    sign_i = 1'b1; exp_i = 8'd200; sig_i = 24'hFFFFFF; guard_i = 1'b1;
    repeat (3) @(negedge clk);
    compared++;
    if ({overflow_o, inexact_o, result_o} !== 34'd0) begin
      mismatched++;
      $display("FAIL R1: got %h, expected 0", {overflow_o, inexact_o, result_o});
    end
    rst_n = 1'b1;
    step("R2", 1'b0, 8'd127, 24'hC00000, 0, 0, 0, 2'd0);
    step("R2", 1'b1, 8'd5,   24'h812345, 0, 0, 0, 2'd3);
    step("R3", 1'b0, 8'd100, 24'h800002, 0, 1, 1, 2'd0);
    step("R3", 1'b0, 8'd100, 24'h800002, 1, 0, 1, 2'd0);
    step("R3", 1'b1, 8'd100, 24'h800002, 1, 1, 0, 2'd0);
    step("R4", 1'b0, 8'd90,  24'h800004, 1, 0, 0, 2'd0);
    step("R4", 1'b0, 8'd90,  24'h800005, 1, 0, 0, 2'd0);
    step("R5", 1'b0, 8'd90,  24'hFFFFFF, 1, 1, 1, 2'd1);
    step("R5", 1'b1, 8'd254, 24'hFFFFFF, 1, 1, 1, 2'd1);
    step("R6", 1'b0, 8'd60,  24'h800010, 0, 0, 1, 2'd2);
    step("R6", 1'b1, 8'd60,  24'h800010, 0, 0, 1, 2'd2);
    step("R6", 1'b1, 8'd60,  24'h800010, 0, 1, 0, 2'd3);
    step("R6", 1'b0, 8'd60,  24'h800010, 1, 0, 0, 2'd3);
    step("R6", 1'b0, 8'd60,  24'h800010, 0, 0, 0, 2'd2);
    step("R7", 1'b0, 8'd10,  24'hFFFFFF, 1, 1, 0, 2'd0);
    step("R7", 1'b1, 8'd10,  24'hFFFFFF, 0, 0, 1, 2'd3);
    step("R8", 1'b0, 8'd0,   24'h7FFFFF, 1, 0, 1, 2'd0);
    step("R8", 1'b0, 8'd0,   24'h000001, 1, 0, 0, 2'd0);
    step("R9", 1'b0, 8'd254, 24'hFFFFFF, 1, 1, 0, 2'd0);
    step("R9", 1'b1, 8'd254, 24'hFFFFFF, 1, 1, 0, 2'd2);
    step("R9", 1'b0, 8'd254, 24'hFFFFFF, 0, 0, 1, 2'd2);
    step("R9", 1'b1, 8'd254, 24'hFFFFFF, 0, 0, 1, 2'd3);
    step("R10", 1'b0, 8'd33, 24'hABCDEF, 0, 0, 1, 2'd1);
    step("R10", 1'b0, 8'd33, 24'hABCDEF, 0, 0, 0, 2'd1);
    for (int i = 0; i < 400; i++) begin
      logic [1:0] md = 2'($urandom_range(0, 3));
      logic [7:0] e = (i % 7 == 0) ? 8'd254 : 8'($urandom_range(1, 254));
      logic [23:0] m = (i % 5 == 0) ? 24'hFFFFFF : {1'b1, 23'($urandom)};
      string tg = (md == 2'd0) ? "R3" : (md == 2'd1) ? "R5" : "R6";
      step(tg, 1'($urandom), e, m, 1'($urandom), 1'($urandom), 1'($urandom), md);
    end
    @(negedge clk);
    compare_one();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule